// File: doc/BRIEF.md
# Interlaced Vertical Timing Generator

This block produces the vertical blanking and vertical sync signals of a display pipeline. It keeps a vertical position counter that is advanced by strobes from the horizontal timing logic. In progressive mode the counter steps once per line, on the line-end strobe. In interlaced mode it steps on every half line, on both the line-end and the mid-line strobe. It also reports which field is being scanned. Blank and sync each have a programmed start count and end count. There is one set of start/end pairs for odd fields and for progressive frames, and a second set that is used only for even fields while interlace is on.

Timing values are written through a small register port into a pending (shadow) copy. They become active only at the next wrap of the vertical counter, which is the start of a frame or field, and only after the update-request bit has been set. The update-request bit reads back as high until that load has happened, so software can tell when the new timing is in effect. Each programmed value is the count at which a signal changes state, minus one. The registered outputs therefore change on the clock edge after the counter equals the programmed value.

Top module: `vert_timing_gen`

## Requirements
- R1: After reset, `vBlank`, `vSync`, `fieldEven`, `updPending` and `vCount` are all zero, and all active and pending timing values are zero.
- R2: When `interlaceEn` is low, `vCount` steps on each clock where `lineEnd` is high. A `midLine` strobe on its own leaves `vCount` unchanged.
- R3: When `interlaceEn` is high, `vCount` steps on each clock where `lineEnd` or `midLine` is high. If both are high in the same clock, it steps only once.
- R4: A step taken while `vCount` equals the active total returns `vCount` to 0. Any other step adds one.
- R5: `vBlank` goes high on the clock after `vCount` equals the selected blank start value. It goes low on the clock after `vCount` equals the selected blank end value. When both values match, the end value wins.
- R6: `vSync` follows the same rules as R5, using the selected sync start and end values.
- R7: `fieldEven` (0 = odd, 1 = even) toggles on each wrap while interlace is on. A wrap in progressive mode forces it to 0.
- R8: The even-field pairs are selected only while `interlaceEn` is high and `fieldEven` is 1. Otherwise the odd pairs are used, so the even-field pairs have no effect in progressive mode.
- R9: A timing write changes only the pending copy. The outputs keep following the old values until a wrap that happens while an update is pending.
- R10: Writing address 0 with data bit 0 set raises `updPending`. The first wrap after that copies every pending value into the active set and clears `updPending`.
- R11: The register map is as follows. Address 1 holds the total in bits 10:0. Address 2 holds the odd blank pair, address 3 the odd sync pair, address 4 the even blank pair and address 5 the even sync pair. In each pair the start value is in bits 10:0 and the end value in bits 26:16. Bits 15:11 and 31:27 are ignored, and so are addresses 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineEnd | input | 1 | One-clock strobe at the end of each line |
| midLine | input | 1 | One-clock strobe in the middle of each line |
| interlaceEn | input | 1 | High selects interlaced scanning |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| vBlank | output | 1 | Vertical blanking, registered |
| vSync | output | 1 | Vertical sync, registered |
| fieldEven | output | 1 | Current field, 1 = even |
| vCount | output | 11 | Vertical position counter |
| updPending | output | 1 | Update request not yet loaded |

## Verification
The bench first writes new timing without requesting an update. Because the active total is still zero, every step wraps and nothing may load, which separates pending storage from active storage. In progressive mode, line-end strobes are mixed with lone mid-line strobes: any count change on a lone mid-line strobe marks wrong interlace gating, and the even-field pairs are set to values that would show on the outputs if they were wrongly selected. The interlaced runs mix lone mid-line strobes, lone line-end strobes and both strobes in one clock, so that double counting and a missing field toggle show up. A final update carries data with the ignored bits set, and it is requested in the middle of a field so that it must wait for the wrap.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CNT_W     = 11;
  localparam int DATA_W    = 32;
  localparam int STOP_LSB  = DATA_W / 2;
  localparam int NUM_PAIRS = 4;
  localparam int HALF_PAIRS = NUM_PAIRS / 2;

  // pair slots: odd set first, even set offset by HALF_PAIRS
  localparam int PAIR_BLANK = 0;
  localparam int PAIR_SYNC  = 1;

  localparam int CTRL_ADDR  = 0;
  localparam int TOTAL_ADDR = 1;
  localparam int PAIR_BASE  = 2;

  typedef struct packed {
    logic [CNT_W-1:0] stopVal;
    logic [CNT_W-1:0] startVal;
  } edgePair_t;

  typedef struct packed {
    logic step;
    logic wrap;
    logic load;
    logic useEven;
  } ctrlStrobe_t;
endpackage

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineEnd,
  input  logic              midLine,
  input  logic              interlaceEn,
  input  logic              atTotal,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrUpdBit,
  output ctrlStrobe_t       stb,
  output logic              fieldEven,
  output logic              updPending
);
  localparam logic [ADDR_W-1:0] CTRL_SEL = ADDR_W'(CTRL_ADDR);

  logic stepNow;
  logic wrapNow;
  logic updReq;

  // half-line strobes only count while interlaced
  assign stepNow = lineEnd | (interlaceEn & midLine);
  assign wrapNow = stepNow & atTotal;
  assign updReq  = wrEn & (wrAddr == CTRL_SEL) & wrUpdBit;

  always_comb begin
    stb.step    = stepNow;
    stb.wrap    = wrapNow;
    stb.load    = wrapNow & updPending;
    stb.useEven = interlaceEn & fieldEven;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldEven <= 1'b0;
    end else if (wrapNow) begin
      fieldEven <= interlaceEn ? ~fieldEven : 1'b0;
    end
  end

  // a request written in the loading clock survives to the next wrap
  always_ff @(posedge clk) begin
    if (!rstN) begin
      updPending <= 1'b0;
    end else begin
      if (stb.load) updPending <= 1'b0;
      if (updReq)   updPending <= 1'b1;
    end
  end
endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrStart,
  input  logic [CNT_W-1:0]  wrStop,
  output logic              atTotal,
  output logic [CNT_W-1:0]  vCount,
  output logic [CNT_W-1:0]  totalAct,
  output edgePair_t         blankSel,
  output edgePair_t         syncSel,
  output logic              vBlank,
  output logic              vSync
);
  localparam logic [ADDR_W-1:0] TOTAL_SEL = ADDR_W'(TOTAL_ADDR);

  logic [CNT_W-1:0] totalPend;
  edgePair_t        pairPend [NUM_PAIRS];
  edgePair_t        pairAct  [NUM_PAIRS];

  // total: shadow and active copy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      totalPend <= '0;
      totalAct  <= '0;
    end else begin
      if (wrEn && wrAddr == TOTAL_SEL) totalPend <= wrStart;
      if (stb.load) totalAct <= totalPend;
    end
  end

  // start/end pairs: shadow and active copies
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        pairPend[i] <= '0;
        pairAct[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_PAIRS; i++) begin
        if (wrEn && wrAddr == ADDR_W'(PAIR_BASE + i)) begin
          pairPend[i].startVal <= wrStart;
          pairPend[i].stopVal  <= wrStop;
        end
        if (stb.load) pairAct[i] <= pairPend[i];
      end
    end
  end

  // vertical position counter
  assign atTotal = (vCount == totalAct);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vCount <= '0;
    end else if (stb.step) begin
      vCount <= stb.wrap ? '0 : vCount + 1'b1;
    end
  end

  // one compare stage per output signal (blank, sync)
  for (genvar k = 0; k < 2; k++) begin : g_edge
    localparam int ODD_IDX  = (k == 0) ? PAIR_BLANK : PAIR_SYNC;
    localparam int EVEN_IDX = ODD_IDX + HALF_PAIRS;

    edgePair_t sel;
    logic      q;

    assign sel = stb.useEven ? pairAct[EVEN_IDX] : pairAct[ODD_IDX];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= 1'b0;
      end else if (vCount == sel.stopVal) begin
        q <= 1'b0;
      end else if (vCount == sel.startVal) begin
        q <= 1'b1;
      end
    end
  end

  assign blankSel = g_edge[0].sel;
  assign syncSel  = g_edge[1].sel;
  assign vBlank   = g_edge[0].q;
  assign vSync    = g_edge[1].q;
endmodule

// File: rtl/vert_timing_gen.sv
module vert_timing_gen
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineEnd,
  input  logic              midLine,
  input  logic              interlaceEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              vBlank,
  output logic              vSync,
  output logic              fieldEven,
  output logic [CNT_W-1:0]  vCount,
  output logic              updPending
);
  ctrlStrobe_t      stb;
  logic             atTotal;
  logic [CNT_W-1:0] totalAct;
  edgePair_t        blankSel;
  edgePair_t        syncSel;
  logic [CNT_W-1:0] wrStart;
  logic [CNT_W-1:0] wrStop;
  logic             unusedRsvd;

  assign wrStart    = wrData[CNT_W-1:0];
  assign wrStop     = wrData[STOP_LSB +: CNT_W];
  assign unusedRsvd = ^{wrData[DATA_W-1:STOP_LSB+CNT_W], wrData[STOP_LSB-1:CNT_W]};

  vtg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .lineEnd    (lineEnd),
    .midLine    (midLine),
    .interlaceEn(interlaceEn),
    .atTotal    (atTotal),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrUpdBit   (wrData[0]),
    .stb        (stb),
    .fieldEven  (fieldEven),
    .updPending (updPending)
  );

  vtg_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrStart (wrStart),
    .wrStop  (wrStop),
    .atTotal (atTotal),
    .vCount  (vCount),
    .totalAct(totalAct),
    .blankSel(blankSel),
    .syncSel (syncSel),
    .vBlank  (vBlank),
    .vSync   (vSync)
  );
endmodule

// File: rtl/vtg_checker.sv
module vtg_checker
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineEnd,
  input logic              midLine,
  input logic              interlaceEn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              vBlank,
  input logic              vSync,
  input logic              fieldEven,
  input logic [CNT_W-1:0]  vCount,
  input logic              updPending,
  input logic [CNT_W-1:0]  totalAct,
  input edgePair_t         blankSel,
  input edgePair_t         syncSel,
  input ctrlStrobe_t       stb
);
  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    vCount <= totalAct);

  p_mid_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!interlaceEn && !lineEnd) |=> $stable(vCount));

  p_half_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (interlaceEn && midLine && vCount != totalAct) |=> vCount == $past(vCount) + 1'b1);

  p_field_odd_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!interlaceEn && lineEnd && vCount == totalAct) |=> !fieldEven);

  p_upd_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && !(wrEn && wrAddr == ADDR_W'(CTRL_ADDR) && wrData[0])) |=> !updPending);

  p_blank_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vBlank) |-> $past(vCount) == $past(blankSel.startVal));

  p_sync_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(vSync) |-> $past(vCount) == $past(syncSel.stopVal));
endmodule

bind vert_timing_gen vtg_checker #(.ADDR_W(ADDR_W)) u_vtg_checker (
  .clk        (clk),
  .rstN       (rstN),
  .lineEnd    (lineEnd),
  .midLine    (midLine),
  .interlaceEn(interlaceEn),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .vBlank     (vBlank),
  .vSync      (vSync),
  .fieldEven  (fieldEven),
  .vCount     (vCount),
  .updPending (updPending),
  .totalAct   (totalAct),
  .blankSel   (blankSel),
  .syncSel    (syncSel),
  .stb        (stb)
);

// File: tb/vert_timing_gen_bench.sv
module vert_timing_gen_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineEnd = 1'b0;
  logic        midLine = 1'b0;
  logic        interlaceEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        vBlank, vSync, fieldEven, updPending;
  logic [10:0] vCount;

  int    testsRun = 0;
  int    testsFailed = 0;
  bit    cmpOn = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  vert_timing_gen u_vert_timing_gen (
    .clk(clk), .rstN(rstN), .lineEnd(lineEnd), .midLine(midLine),
    .interlaceEn(interlaceEn), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vBlank(vBlank), .vSync(vSync), .fieldEven(fieldEven), .vCount(vCount),
    .updPending(updPending)
  );

  // reference model: index 0 = total, 1..4 = pairs (odd blank, odd sync, even blank, even sync)
  int mPendS[5];
  int mPendE[5];
  int mActS[5];
  int mActE[5];
  int mCount, mField, mBlank, mSync, mUpd;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 5; i++) begin
        mPendS[i] = 0; mPendE[i] = 0; mActS[i] = 0; mActE[i] = 0;
      end
      mCount = 0; mField = 0; mBlank = 0; mSync = 0; mUpd = 0;
    end else begin
      int  bi, si, nCount, nField, nUpd;
      bit  stepIt;
      bi = (interlaceEn && mField == 1) ? 3 : 1;
      si = bi + 1;
      if (mCount == mActE[bi]) mBlank = 0;
      else if (mCount == mActS[bi]) mBlank = 1;
      if (mCount == mActE[si]) mSync = 0;
      else if (mCount == mActS[si]) mSync = 1;
      stepIt = lineEnd || (interlaceEn && midLine);
      nCount = mCount; nField = mField; nUpd = mUpd;
      if (stepIt) begin
        if (mCount == mActS[0]) begin
          nCount = 0;
          nField = interlaceEn ? 1 - mField : 0;
          if (mUpd == 1) begin
            for (int i = 0; i < 5; i++) begin
              mActS[i] = mPendS[i]; mActE[i] = mPendE[i];
            end
            nUpd = 0;
          end
        end else begin
          nCount = mCount + 1;
        end
      end
      if (wrEn) begin
        if (wrAddr == 0 && wrData[0]) nUpd = 1;
        else if (wrAddr == 1) mPendS[0] = int'(wrData[10:0]);
        else if (wrAddr >= 2 && wrAddr <= 5) begin
          mPendS[wrAddr - 1] = int'(wrData[10:0]);
          mPendE[wrAddr - 1] = int'(wrData[26:16]);
        end
      end
      mCount = nCount; mField = nField; mUpd = nUpd;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && rstN) begin
      check("vCount", int'(vCount), mCount);
      check("fieldEven", int'(fieldEven), mField);
      check("vBlank", int'(vBlank), mBlank);
      check("vSync", int'(vSync), mSync);
      check("updPending", int'(updPending), mUpd);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic tick(input logic le, input logic ml);
    @(negedge clk);
    lineEnd = le; midLine = ml;
    @(negedge clk);
    lineEnd = 1'b0; midLine = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tag = "R1";
    check("reset vBlank", int'(vBlank), 0);
    check("reset vSync", int'(vSync), 0);
    check("reset fieldEven", int'(fieldEven), 0);
    check("reset vCount", int'(vCount), 0);
    check("reset updPending", int'(updPending), 0);
    cmpOn = 1'b1;

    // R9: pending writes without a request must not reach the outputs
    tag = "R9 R11";
    wr(3'd1, 32'd9);
    wr(3'd2, {16'd9, 16'd6});
    wr(3'd3, {16'd8, 16'd7});
    wr(3'd4, {16'd5, 16'd2});
    wr(3'd5, {16'd3, 16'd3});
    wr(3'd6, 32'h0001_0001);
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0);
    check("R9 count held at zero", int'(vCount), 0);

    tag = "R10";
    wr(3'd0, 32'd1);
    check("R10 pending raised", int'(updPending), 1);
    tick(1'b1, 1'b0);
    @(negedge clk);
    check("R10 pending cleared after wrap", int'(updPending), 0);

    // progressive, lone mid-line strobes mixed in
    tag = "R2 R4 R5 R6 R8";
    for (int i = 0; i < 30; i++) begin
      tick(1'b1, 1'b0);
      if (i % 3 == 0) tick(1'b0, 1'b1);
    end
    check("R8 progressive field odd", int'(fieldEven), 0);

    // interlaced half-line stepping
    tag = "R3 R5 R6 R7 R8";
    @(negedge clk);
    interlaceEn = 1'b1;
    for (int i = 0; i < 48; i++) begin
      if (i % 7 == 6) tick(1'b1, 1'b1);
      else tick(1'b0, 1'b1);
      tick(1'b1, 1'b0);
    end

    // update in mid-field with ignored bits set
    tag = "R9 R10 R11";
    wr(3'd1, 32'hF800_F80C);
    wr(3'd2, 32'hF80A_F809);
    wr(3'd3, 32'hF80B_F80A);
    wr(3'd4, 32'hF804_F801);
    wr(3'd5, 32'hF806_F802);
    wr(3'd0, 32'hFFFF_FFFF);
    check("R10 pending raised mid-field", int'(updPending), 1);
    for (int i = 0; i < 40; i++) begin
      tick(1'b0, 1'b1);
      tick(1'b1, 1'b0);
    end

    // back to progressive: field forced odd at wrap
    tag = "R2 R7 R8";
    @(negedge clk);
    interlaceEn = 1'b0;
    for (int i = 0; i < 30; i++) tick(1'b1, (i % 2) == 1);
    check("R7 field odd in progressive", int'(fieldEven), 0);

    cmpOn = 1'b0;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule